// File: doc/BRIEF.md
# Held-Button Storage Wipe Controller

This block wipes the general-purpose area of a small battery-backed byte store when a user holds a pushbutton. The button input is active low. It is synchronised into the system clock domain and then timed with a slow tick enable derived from the 32.768 kHz oscillator. A wipe is accepted only after the button has stayed low without a break for a set number of ticks, and only while the oscillator-running flag is high.

Once a wipe is accepted, a sequencer takes over the store's single write port. It writes all-ones to each general-purpose address in ascending order, one byte per system clock. The low addresses hold the timekeeping and control registers, and they are never written by the wipe. Ordinary bus writes pass straight through to the store when no wipe is running. While a wipe is running they are dropped, and a busy output is raised.

Each press produces exactly one wipe. The button must be released before another wipe can be armed.

Top module: `ram_clear_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `mem_we` is 0 while no bus write is requested.
- R2: While `busy` is 0, a bus write reaches the storage port unchanged: `mem_we`, `mem_addr` and `mem_wdata` follow `bus_we`, `bus_addr` and `bus_wdata` in the same cycle.
- R3: A wipe starts only after HOLD_TICKS tick pulses (4096 by default, which is 125 ms at 32.768 kHz) have been seen with the synchronised button low. HOLD_TICKS-1 ticks followed by a release start nothing.
- R4: Releasing the button clears the tick count. Two presses that are each shorter than HOLD_TICKS never add up to a wipe.
- R5: While `osc_run` is 0, the tick count is held at zero, so no wipe can be armed.
- R6: A wipe raises `busy` for exactly USER_BYTES cycles, starting the cycle after the tick that completes the hold. In each of those cycles it drives `mem_we`=1 and `mem_wdata`=all-ones, with `mem_addr` stepping by one from FIRST_USER (14 by default) up to FIRST_USER+USER_BYTES-1 (127 by default).
- R7: Addresses below FIRST_USER (the 14 clock and control locations, 0 to 13) are never written by a wipe.
- R8: While `busy` is 1, bus writes are dropped and leave no trace in the store.
- R9: Holding the button after a wipe does not start another. A new wipe needs a release and then a fresh full hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n | input | 1 | Pushbutton, low = pressed (asynchronous) |
| osc_run | input | 1 | High while the oscillator is running and power is valid |
| tick | input | 1 | One-cycle pulse per 32.768 kHz oscillator period |
| bus_we | input | 1 | Bus write request |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | DATA_W | Bus write data |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | ADDR_W | Storage write address |
| mem_wdata | output | DATA_W | Storage write data |
| busy | output | 1 | High while a wipe is in progress |

## Verification
The bench lowers HOLD_TICKS to 16 and keeps the default 7-bit address, 14 protected locations and 114 wiped bytes. With that setting the hold threshold can be probed on both sides (15 ticks versus 16) in a few hundred cycles. The full wipe still runs through the real address range, so the boundary addresses 13, 14 and 127 are all observed. The bench keeps a model of the store fed from the write port, and checks the fill order, length and contents against it.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WALK = 1'b1
    } seq_state_e;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic pressed
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], raw_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign pressed = ~sh_q[STAGES-1];
endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer #(
    parameter int unsigned HOLD_TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pressed,
    input  logic osc_run,
    input  logic tick,
    output logic accept
);
    localparam int unsigned CNT_W = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             spent;
        logic             accept;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        if (!pressed) begin
            st_d.cnt   = '0;
            st_d.spent = 1'b0;
        end else if (!osc_run) begin
            st_d.cnt = '0;
        end else if (!st_q.spent && tick) begin
            if (st_q.cnt == CNT_W'(HOLD_TICKS - 1)) begin
                st_d.cnt    = '0;
                st_d.spent  = 1'b1;
                st_d.accept = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept = st_q.accept;

    // R3: acceptance follows a qualified tick
    a_r3_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(pressed && osc_run && tick));
    // R9: one acceptance per press
    a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    // R5: no acceptance right after the oscillator is seen stopped
    a_r5_osc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> !accept);
    // R4: a release leaves the count empty
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !pressed |=> (st_q.cnt == '0));
endmodule

// File: rtl/rcc_fill_seq.sv
module rcc_fill_seq
    import rcc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned FIRST_USER = 14,
    parameter int unsigned USER_BYTES = 114
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned LAST_USER = FIRST_USER + USER_BYTES - 1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.st   = SEQ_WALK;
                    s_d.addr = ADDR_W'(FIRST_USER);
                end
            end
            SEQ_WALK: begin
                if (s_q.addr == ADDR_W'(LAST_USER)) s_d.st = SEQ_IDLE;
                else                                s_d.addr = s_q.addr + 1'b1;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, addr: '0};
        else        s_q <= s_d;
    end

    assign busy = (s_q.st == SEQ_WALK);
    assign addr = s_q.addr;

    // R6: walk stays inside the user range
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr >= ADDR_W'(FIRST_USER) && addr <= ADDR_W'(LAST_USER)));
    // R6: ascending by one each cycle
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (addr == $past(addr) + 1'b1));
    // R6: a walk begins at the first user byte
    a_r6_begin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (addr == ADDR_W'(FIRST_USER)));
endmodule

// File: rtl/ram_clear_ctrl.sv
module ram_clear_ctrl #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned FIRST_USER  = 14,
    parameter int unsigned USER_BYTES  = 114,
    parameter int unsigned HOLD_TICKS  = 4096,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              osc_run,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    logic              pressed;
    logic              accept;
    logic              walk;
    logic [ADDR_W-1:0] walk_addr;

    rcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_n(clr_n), .pressed(pressed)
    );

    rcc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .pressed(pressed), .osc_run(osc_run),
        .tick(tick), .accept(accept)
    );

    rcc_fill_seq #(
        .ADDR_W(ADDR_W), .FIRST_USER(FIRST_USER), .USER_BYTES(USER_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .busy(walk), .addr(walk_addr)
    );

    always_comb begin
        if (walk) begin
            mem_we    = 1'b1;
            mem_addr  = walk_addr;
            mem_wdata = '1;
        end else begin
            mem_we    = bus_we;
            mem_addr  = bus_addr;
            mem_wdata = bus_wdata;
        end
    end

    assign busy = walk;

    // R8: no write into protected locations while busy
    a_r8_bus_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_addr >= ADDR_W'(FIRST_USER)));
    // R7: protected locations only ever see bus writes
    a_r7_ctrl_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr < ADDR_W'(FIRST_USER)) |-> (!busy && bus_we));
    // R1: quiet after reset with no bus request
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_we) |-> !mem_we);
endmodule

// File: tb/ram_clear_ctrl_bench.sv
module ram_clear_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;
    localparam int DW = 8;
    localparam int FIRST = 14;
    localparam int NUSER = 114;
    localparam int HOLD = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic osc_run = 1'b1;
    logic tick = 1'b0;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic busy;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] mem [DEPTH];
    int starts = 0;
    int writes = 0;
    int order_err = 0;
    int exp_addr = 0;
    logic busy_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_clear_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .FIRST_USER(FIRST),
        .USER_BYTES(NUSER), .HOLD_TICKS(HOLD)
    ) u_ram_clear_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .osc_run(osc_run),
        .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    // storage model and wipe monitor
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (busy) begin
            if (!busy_prev) begin
                starts   = starts + 1;
                exp_addr = FIRST;
            end
            writes = writes + 1;
            if (int'(mem_addr) != exp_addr || mem_wdata != 8'hFF || !mem_we)
                order_err = order_err + 1;
            exp_addr = exp_addr + 1;
        end
        busy_prev = busy;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic press();
        @(negedge clk); clr_n = 1'b0;
        cyc(4);
    endtask

    task automatic release_btn();
        @(negedge clk); clr_n = 1'b1;
        cyc(4);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 mem_we after reset", int'(mem_we), 0);
    endtask

    task automatic t_bus_pass();
        for (int a = 0; a < DEPTH; a++) bus_write(a, (a < FIRST) ? (a + 8'h40) : 0);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 7'd20; bus_wdata = 8'h5A;
        #1;
        chk("R2 pass we", int'(mem_we), 1);
        chk("R2 pass addr", int'(mem_addr), 20);
        chk("R2 pass data", int'(mem_wdata), 8'h5A);
        @(negedge clk); bus_we = 1'b0;
        cyc(1);
        chk("R2 stored byte", int'(mem[20]), 8'h5A);
        chk("R2 stored ctrl", int'(mem[3]), 8'h43);
    endtask

    task automatic t_short();
        int s0 = starts;
        press(); pulse_ticks(HOLD - 1); release_btn();
        cyc(5);
        chk("R3 one tick short", starts - s0, 0);
    endtask

    task automatic t_split();
        int s0 = starts;
        press(); pulse_ticks(10); release_btn();
        press(); pulse_ticks(10); release_btn();
        cyc(5);
        chk("R4 split presses", starts - s0, 0);
    endtask

    task automatic t_osc();
        int s0 = starts;
        osc_run = 1'b0;
        press(); pulse_ticks(HOLD + 4); release_btn();
        osc_run = 1'b1;
        chk("R5 osc stopped", starts - s0, 0);
        press(); pulse_ticks(10);
        @(negedge clk); osc_run = 1'b0;
        @(negedge clk); osc_run = 1'b1;
        pulse_ticks(10); release_btn();
        cyc(5);
        chk("R5 osc gap restarts count", starts - s0, 0);
    endtask

    task automatic t_long();
        int s0 = starts;
        int w0 = writes;
        int bad = 0;
        int keep = 0;
        press(); pulse_ticks(HOLD);
        cyc(3);
        chk("R6 busy after hold", int'(busy), 1);
        bus_write(5, 8'h11);
        cyc(NUSER + 10);
        chk("R8 blocked ctrl write", int'(mem[5]), 8'h45);
        chk("R6 one start", starts - s0, 1);
        chk("R6 write count", writes - w0, NUSER);
        chk("R6 order/data errors", order_err, 0);
        for (int a = FIRST; a < FIRST + NUSER; a++) if (mem[a] != 8'hFF) bad++;
        chk("R6 user bytes all ones", bad, 0);
        for (int a = 0; a < FIRST; a++) if (a != 5 && mem[a] != DW'(a + 8'h40)) keep++;
        chk("R7 ctrl bytes kept", keep, 0);
        chk("R7 ctrl byte 13", int'(mem[13]), 8'h4D);
        pulse_ticks(HOLD * 2);
        chk("R9 held no rewipe", starts - s0, 1);
        chk("R9 busy low while held", int'(busy), 0);
        release_btn();
        bus_write(30, 8'h12);
        chk("R2 user byte set", int'(mem[30]), 8'h12);
        press(); pulse_ticks(HOLD);
        cyc(NUSER + 10);
        release_btn();
        chk("R9 second press wipes", starts - s0, 2);
        chk("R9 byte rewiped", int'(mem[30]), 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_bus_pass();
        t_short();
        t_split();
        t_osc();
        t_long();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule